// File: doc/BRIEF.md
# TDM Frame-Sync Receiver and Checker

This block recovers bit timing from an externally driven bit clock and frame sync on a serial time-division multiplexed link, with the local side acting as the timing slave. Both link inputs are oversampled by a fast system clock through a two-flop synchroniser. A change in bit-clock level is accepted only after a programmable run of identical samples, which filters out glitches. On the chosen start edge, the block emits a one-cycle bit strobe. That strobe is moved in time by a signed offset, and the offset already includes the filter and synchroniser latency.

A programmable number of system clocks after each bit strobe, the frame-sync line is sampled once to produce one sync bit per bit time. The first sync pulse found while searching aligns a free-running bit counter, whose period is the configured frame length. From then on, every frame is checked for exactly one sync pulse at the expected position. The result appears as a sticky status bit and as one-cycle miss and extra event pulses. A frame-start strobe marks bit 0 of every frame.

Top module: `tdm_sync_rx`

## Requirements
- R1: A new bit-clock level is accepted only after `edge_samples_i` consecutive synchronised samples at that level, and a value of 0 acts as 1. A pulse shorter than that run produces no bit strobe.
- R2: `bit_stb_o` is a one-cycle pulse on the start edge only. The start edge is rising when `bclk_pol_i`=0 and falling when it is 1. The strobe is high in the cycle after clock edge number `edge_samples_i`+3+`edge_shift_i` (signed), where edge 0 is the first edge at which `bclk_i` shows its new level. A shift below -2 behaves as -2. The opposite edge produces no strobe.
- R3: The sync bit for a bit time is `fsync_i` as it stood at clock edge number `edge_samples_i`+`edge_shift_i`+`fsync_delay_i`+2, counted as in R2. It is taken as asserted when that level is high for `fsync_pol_i`=0 and low for `fsync_pol_i`=1.
- R4: A frame is `slot_count_i`*8+`frame_bit_i` bits long. Sync is expected `sync_lead_i` bits before bit 0, or at bit 0 when the lead is 0. The first sync start seen while searching aligns the bit counter, which then free-runs. `frame_stb_o` pulses once each time the counter reaches bit 0.
- R5: At each expected sync position, `sync_good_o` is set to 1 when a sync start is present there and no other sync start occurred since the previous expected position, and to 0 otherwise. It holds that value until the next expected position.
- R6: `sync_miss_o` pulses for one cycle at an expected position that holds no sync start.
- R7: `sync_extra_o` pulses for one cycle at an expected position when a sync start occurred elsewhere in the preceding frame.
- R8: While `enable_i` is 0, all outputs are 0. Setting `enable_i` to 1 starts a new search for sync.
- R9: A sync start is an inactive-to-active change of the sync bit. A pulse several bits wide counts once.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Receiver enable; 0 holds the block idle |
| bclk_i | input | 1 | External bit clock, asynchronous |
| fsync_i | input | 1 | External frame sync, asynchronous |
| bclk_pol_i | input | 1 | 0: rising edge starts a bit; 1: falling edge |
| fsync_pol_i | input | 1 | 0: sync asserted high; 1: asserted low |
| edge_samples_i | input | CNT_W | Stable samples needed to accept a bit-clock edge |
| edge_shift_i | input | CNT_W | Signed extra shift of the bit strobe |
| fsync_delay_i | input | CNT_W | System clocks from bit strobe to sync sample |
| slot_count_i | input | SLOT_W | 8-bit slots per frame |
| frame_bit_i | input | 1 | Adds one framing bit per frame |
| sync_lead_i | input | LEAD_W | Bits by which sync precedes bit 0 |
| bit_stb_o | output | 1 | Internal bit-time strobe |
| frame_stb_o | output | 1 | Bit 0 of a frame reached |
| sync_good_o | output | 1 | Last checked frame held exactly one correct sync |
| sync_miss_o | output | 1 | No sync at the expected position |
| sync_extra_o | output | 1 | Sync seen off the expected position |

## Verification
The hardest situation to reach is a frame verdict that reflects something other than a clean frame. That requires the counter to be locked first and then to see a stray sync start, a missing one, or both in the same frame. The stimulus plays whole frames bit by bit, with the sync pattern given as a bit mask. One lock pulse is followed by a frame with an off-position pulse, a dropped pulse, or a pulse moved one bit early. The same masks are then replayed with the sync driven only in the second half of each bit. Whether lock happens at all then depends on the sampling delay alone.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2
  } frm_state_e;
endpackage

// File: rtl/tdm_sync_cdc.sv
module tdm_sync_cdc #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tdm_sync_edge.sv
module tdm_sync_edge #(
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    lvl_i,
  input  logic                    pol_i,
  input  logic [CNT_W-1:0]        nsamp_i,
  input  logic signed [CNT_W-1:0] shift_i,
  output logic                    stb_o
);
  localparam int DLY_W = CNT_W + 1;

  logic [CNT_W-1:0] nsamp_eff, run_q;
  logic [DLY_W-1:0] dly_q, wait_d;
  logic [DLY_W:0]   wait_s;
  logic             level_q, pend_q, stb_q, run_done, start_edge;

  assign nsamp_eff  = (nsamp_i == '0) ? CNT_W'(1) : nsamp_i;
  assign run_done   = ({1'b0, run_q} + (CNT_W+1)'(1)) >= {1'b0, nsamp_eff};
  assign start_edge = lvl_i ^ pol_i;
  // filter plus sync latency already spent; remainder is 2 + shift
  assign wait_s     = {{2{shift_i[CNT_W-1]}}, shift_i} + (DLY_W+1)'(2);
  assign wait_d     = wait_s[DLY_W] ? '0 : wait_s[DLY_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      run_q   <= '0;
      pend_q  <= 1'b0;
      dly_q   <= '0;
      stb_q   <= 1'b0;
    end else if (!en_i) begin
      level_q <= lvl_i;
      run_q   <= '0;
      pend_q  <= 1'b0;
      dly_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (pend_q) begin
        if (dly_q == DLY_W'(1)) begin
          stb_q  <= 1'b1;
          pend_q <= 1'b0;
        end
        dly_q <= dly_q - DLY_W'(1);
      end
      if (lvl_i != level_q) begin
        if (run_done) begin
          level_q <= lvl_i;
          run_q   <= '0;
          if (start_edge) begin
            if (wait_d == '0) begin
              stb_q  <= 1'b1;
              pend_q <= 1'b0;
            end else begin
              pend_q <= 1'b1;
            end
            dly_q <= wait_d;
          end
        end else begin
          run_q <= run_q + CNT_W'(1);
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign stb_o = stb_q;
endmodule

// File: rtl/tdm_sync_sample.sv
module tdm_sync_sample #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             lvl_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic             bit_stb_i,
  output logic             vld_o,
  output logic             val_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, vld_q, val_q, act;

  assign act = lvl_i ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      val_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      val_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (pend_q) begin
        if (cnt_q == CNT_W'(1)) begin
          vld_q  <= 1'b1;
          val_q  <= act;
          pend_q <= 1'b0;
        end
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (bit_stb_i) begin
        if (delay_i == '0) begin
          vld_q  <= 1'b1;
          val_q  <= act;
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
          cnt_q  <= delay_i;
        end
      end
    end
  end

  assign vld_o = vld_q;
  assign val_o = val_q;
endmodule

// File: rtl/tdm_sync_frame.sv
module tdm_sync_frame
  import tdm_sync_pkg::*;
#(
  parameter int SLOT_W = 10,
  parameter int LEAD_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              samp_vld_i,
  input  logic              samp_val_i,
  input  logic [SLOT_W-1:0] slots_i,
  input  logic              frame_bit_i,
  input  logic [LEAD_W-1:0] lead_i,
  output logic              frame_stb_o,
  output logic              good_o,
  output logic              miss_o,
  output logic              extra_o
);
  localparam int LEN_W = SLOT_W + 4;

  frm_state_e       state_q;
  logic [LEN_W-1:0] frame_len, len_eff, lead_ext, exp_pos, idx_q, nidx;
  logic             prev_q, xtra_q, frm_q, good_q, miss_q, extra_q, start;

  assign frame_len = {1'b0, slots_i, 3'b000} + LEN_W'(frame_bit_i);
  assign len_eff   = (frame_len == '0) ? LEN_W'(1) : frame_len;
  assign lead_ext  = LEN_W'(lead_i);
  assign exp_pos   = (lead_ext == '0 || lead_ext >= len_eff) ? '0 : len_eff - lead_ext;
  assign nidx      = (idx_q >= len_eff - LEN_W'(1)) ? '0 : idx_q + LEN_W'(1);
  assign start     = samp_val_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      prev_q  <= 1'b0;
      xtra_q  <= 1'b0;
      frm_q   <= 1'b0;
      good_q  <= 1'b0;
      miss_q  <= 1'b0;
      extra_q <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      prev_q  <= 1'b0;
      xtra_q  <= 1'b0;
      frm_q   <= 1'b0;
      good_q  <= 1'b0;
      miss_q  <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      frm_q   <= 1'b0;
      miss_q  <= 1'b0;
      extra_q <= 1'b0;
      if (state_q == ST_IDLE) state_q <= ST_HUNT;
      if (samp_vld_i) begin
        prev_q <= samp_val_i;
        case (state_q)
          ST_HUNT: begin
            if (start) begin
              state_q <= ST_LOCK;
              idx_q   <= exp_pos;
              frm_q   <= (exp_pos == '0);
              xtra_q  <= 1'b0;
            end
          end
          ST_LOCK: begin
            idx_q <= nidx;
            frm_q <= (nidx == '0);
            if (nidx == exp_pos) begin
              miss_q  <= ~start;
              extra_q <= xtra_q;
              good_q  <= start & ~xtra_q;
              xtra_q  <= 1'b0;
            end else if (start) begin
              xtra_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign frame_stb_o = frm_q;
  assign good_o      = good_q;
  assign miss_o      = miss_q;
  assign extra_o     = extra_q;
endmodule

// File: rtl/tdm_sync_rx.sv
module tdm_sync_rx #(
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 10,
  parameter int LEAD_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic                    bclk_i,
  input  logic                    fsync_i,
  input  logic                    bclk_pol_i,
  input  logic                    fsync_pol_i,
  input  logic [CNT_W-1:0]        edge_samples_i,
  input  logic signed [CNT_W-1:0] edge_shift_i,
  input  logic [CNT_W-1:0]        fsync_delay_i,
  input  logic [SLOT_W-1:0]       slot_count_i,
  input  logic                    frame_bit_i,
  input  logic [LEAD_W-1:0]       sync_lead_i,
  output logic                    bit_stb_o,
  output logic                    frame_stb_o,
  output logic                    sync_good_o,
  output logic                    sync_miss_o,
  output logic                    sync_extra_o
);
  localparam int SYNC_STAGES = 2;

  logic [1:0] pins_s;
  logic       samp_vld, samp_val;

  tdm_sync_cdc #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_cdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({fsync_i, bclk_i}),
    .q_o    (pins_s)
  );

  tdm_sync_edge #(.CNT_W(CNT_W)) i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (enable_i),
    .lvl_i   (pins_s[0]),
    .pol_i   (bclk_pol_i),
    .nsamp_i (edge_samples_i),
    .shift_i (edge_shift_i),
    .stb_o   (bit_stb_o)
  );

  tdm_sync_sample #(.CNT_W(CNT_W)) i_sample (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (enable_i),
    .lvl_i     (pins_s[1]),
    .pol_i     (fsync_pol_i),
    .delay_i   (fsync_delay_i),
    .bit_stb_i (bit_stb_o),
    .vld_o     (samp_vld),
    .val_o     (samp_val)
  );

  tdm_sync_frame #(.SLOT_W(SLOT_W), .LEAD_W(LEAD_W)) i_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (enable_i),
    .samp_vld_i  (samp_vld),
    .samp_val_i  (samp_val),
    .slots_i     (slot_count_i),
    .frame_bit_i (frame_bit_i),
    .lead_i      (sync_lead_i),
    .frame_stb_o (frame_stb_o),
    .good_o      (sync_good_o),
    .miss_o      (sync_miss_o),
    .extra_o     (sync_extra_o)
  );
endmodule

// File: rtl/tdm_sync_rx_sva.sv
module tdm_sync_rx_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic bit_stb_o,
  input logic frame_stb_o,
  input logic sync_good_o,
  input logic sync_miss_o,
  input logic sync_extra_o,
  input logic samp_vld_i
);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !bit_stb_o && !frame_stb_o && !sync_good_o && !sync_miss_o && !sync_extra_o);

  a_r6_miss_not_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_miss_o |-> !sync_good_o);

  a_r7_extra_not_good: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_extra_o |-> !sync_good_o);

  a_r5_good_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_good_o) |-> !sync_miss_o && !sync_extra_o);

  a_r4_frame_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> $past(samp_vld_i));

  a_r5_good_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_good_o != $past(sync_good_o)) && enable_i && $past(enable_i) |-> $past(samp_vld_i));
endmodule

bind tdm_sync_rx tdm_sync_rx_sva i_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .bit_stb_o    (bit_stb_o),
  .frame_stb_o  (frame_stb_o),
  .sync_good_o  (sync_good_o),
  .sync_miss_o  (sync_miss_o),
  .sync_extra_o (sync_extra_o),
  .samp_vld_i   (samp_vld)
);

// File: tb/test_tdm_sync_rx.sv
module test_tdm_sync_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, bclk = 1'b0, fsync = 1'b0, bpol = 1'b0, fpol = 1'b0;
  logic [15:0] nsamp = 16'd2, fdly = 16'd2;
  logic signed [15:0] shift = '0;
  logic [9:0] slots = 10'd1;
  logic fbit = 1'b1;
  logic [4:0] lead = 5'd1;
  logic bit_stb, frame_stb, sync_good, sync_miss, sync_extra;

  int n_chk = 0, n_fail = 0;
  int n_stb = 0, n_frm = 0, n_miss = 0, n_extra = 0;
  int d_stb, d_frm, d_miss, d_extra;
  logic g_end;
  bit done = 0;

  // {edge_samples, edge_shift, bclk_pol, expected strobe edge}
  localparam int EDGE_VEC [7][4] = '{
    '{1,  0, 0,  4},
    '{3,  0, 0,  6},
    '{5,  4, 0, 12},
    '{2, -2, 0,  3},
    '{2, -7, 0,  3},
    '{0,  0, 0,  4},
    '{4,  1, 1,  8}
  };

  always #2.5 clk = ~clk;

  tdm_sync_rx i_tdm_sync_rx (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .bclk_i(bclk), .fsync_i(fsync),
    .bclk_pol_i(bpol), .fsync_pol_i(fpol), .edge_samples_i(nsamp),
    .edge_shift_i(shift), .fsync_delay_i(fdly), .slot_count_i(slots),
    .frame_bit_i(fbit), .sync_lead_i(lead), .bit_stb_o(bit_stb),
    .frame_stb_o(frame_stb), .sync_good_o(sync_good), .sync_miss_o(sync_miss),
    .sync_extra_o(sync_extra)
  );

  always @(negedge clk) begin
    if (bit_stb)    n_stb++;
    if (frame_stb)  n_frm++;
    if (sync_miss)  n_miss++;
    if (sync_extra) n_extra++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic edge_vec(input int n, input int d, input int pol, input int expk);
    int found, cnt;
    en = 0; nsamp = 16'(n); shift = 16'(d); bpol = pol[0]; bclk = pol[0];
    repeat (4) @(negedge clk);
    en = 1;
    repeat (4) @(negedge clk);
    bclk = ~pol[0];
    found = -1; cnt = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (bit_stb) begin
        if (found < 0) found = k;
        cnt++;
      end
    end
    check("R2 strobe edge", found, expk);
    check("R2 single strobe", cnt, 1);
    bclk = pol[0];
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bit_stb) cnt++;
    end
    check("R2 opposite edge", cnt, 0);
  endtask

  task automatic drive_bit(input logic h0, input logic h1);
    bclk = ~bpol; fsync = h0 ^ fpol;
    repeat (8) @(negedge clk);
    bclk = bpol;  fsync = h1 ^ fpol;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_frames(input int nbits, input logic [63:0] m0, input logic [63:0] m1);
    int b_stb, b_frm, b_miss, b_extra;
    @(negedge clk);
    en = 0; bclk = bpol; fsync = fpol;
    repeat (4) @(negedge clk);
    @(posedge clk);
    b_stb = n_stb; b_frm = n_frm; b_miss = n_miss; b_extra = n_extra;
    @(negedge clk);
    en = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) drive_bit(m0[i], m1[i]);
    repeat (24) @(negedge clk);
    g_end = sync_good;
    @(posedge clk);
    d_stb = n_stb - b_stb; d_frm = n_frm - b_frm;
    d_miss = n_miss - b_miss; d_extra = n_extra - b_extra;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {bit_stb, frame_stb, sync_good, sync_miss, sync_extra}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R10 outputs after release", {bit_stb, frame_stb, sync_good, sync_miss, sync_extra}, 0);

    for (int i = 0; i < 7; i++)
      edge_vec(EDGE_VEC[i][0], EDGE_VEC[i][1], EDGE_VEC[i][2], EDGE_VEC[i][3]);

    // R1 glitch filter
    en = 0; nsamp = 16'd4; shift = '0; bpol = 0; bclk = 0;
    repeat (4) @(negedge clk);
    en = 1;
    repeat (4) @(negedge clk);
    bclk = 1; repeat (3) @(negedge clk); bclk = 0;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (bit_stb) cnt++; end
    check("R1 short pulse ignored", cnt, 0);
    bclk = 1; repeat (4) @(negedge clk); bclk = 0;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (bit_stb) cnt++; end
    check("R1 full run accepted", cnt, 1);

    // frame scenarios: 9-bit frame, sync one bit before bit 0
    nsamp = 16'd2; shift = '0; fdly = 16'd2; slots = 10'd1; fbit = 1; lead = 5'd1;
    bpol = 0; fpol = 0;
    run_frames(37, 64'h0000_0008_0402_0100, 64'h0);
    check("R4 frame strobes clean", d_frm, 4);
    check("R5 good after clean frames", g_end, 1);
    check("R6 no miss clean", d_miss, 0);
    check("R7 no extra clean", d_extra, 0);

    run_frames(30, 64'h0000_0000_0002_0100, 64'h0);
    check("R6 dropped sync miss", d_miss, 1);
    check("R5 dropped sync not good", g_end, 0);
    check("R4 frames with drop", d_frm, 3);

    run_frames(22, 64'h0000_0000_0002_1100, 64'h0);
    check("R7 stray sync extra", d_extra, 1);
    check("R6 stray sync no miss", d_miss, 0);
    check("R5 stray sync not good", g_end, 0);

    run_frames(20, 64'h0000_0000_0001_0100, 64'h0);
    check("R6 early sync miss", d_miss, 1);
    check("R7 early sync extra", d_extra, 1);

    // R3: sync only in second half of each bit
    fdly = 16'd8;
    run_frames(37, 64'h0, 64'h0000_0008_0402_0100);
    check("R3 late sample locks", d_frm, 4);
    check("R3 late sample good", g_end, 1);
    fdly = 16'd2;
    run_frames(37, 64'h0, 64'h0000_0008_0402_0100);
    check("R3 early sample no lock", d_frm, 0);
    check("R3 early sample not good", g_end, 0);

    // R9 + inverted sync: 8-bit frame, sync at bit 0, two bits wide
    fpol = 1; fbit = 0; lead = 5'd0;
    run_frames(30, 64'h0000_0000_1818_1818, 64'h0000_0000_1818_1818);
    check("R9 wide pulse no extra", d_extra, 0);
    check("R9 wide pulse no miss", d_miss, 0);
    check("R3 inverted sync good", g_end, 1);
    check("R4 frames incl lock bit", d_frm, 4);

    // R8 idle
    @(negedge clk);
    en = 0;
    repeat (2) @(negedge clk);
    check("R8 good cleared", sync_good, 0);
    @(posedge clk);
    cnt = n_stb;
    @(negedge clk);
    for (int i = 0; i < 5; i++) drive_bit(1'b1, 1'b0);
    @(posedge clk);
    check("R8 no strobe when idle", n_stb - cnt, 0);
    fpol = 0; fbit = 1; lead = 5'd1;
    run_frames(37, 64'h0000_0008_0402_0100, 64'h0);
    check("R8 relock after enable", g_end, 1);

    finish_run();
  end
endmodule